// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command bus from reset until the memory can accept ordinary traffic. While power settles it shows only no-operation commands, with clock enable and the data mask held high. After that settling delay it closes every bank with one precharge-all command and runs a fixed number of auto-refresh commands. It then writes a mode word that is assembled from parameters. Once the mode-set recovery time has passed, it raises a ready flag that stays high until the next reset.

Every delay is a parameter counted in clock cycles, so one netlist can serve several clock rates. Each delay is measured from one command cycle to the next command cycle. The external reset asserts asynchronously. It is released into the sequencer through a two-stage synchronizer, so counting starts two clock edges after the reset input rises. The block leaves normal reads, writes and periodic refresh to the controller that takes over once the ready flag is high.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, the bus shows NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), `sd_addr` and `sd_ba` are zero and `init_done` is low. This takes effect without waiting for a clock edge.
- R2: Counting the clock edges after `rst_n` rises, the first non-NOP command appears after edge T_PAUSE+2: two edges for the reset synchronizer and T_PAUSE cycles of settling. Every earlier cycle is NOP.
- R3: `sd_cke` and `sd_dqm` are high in every cycle, during reset and during the sequence.
- R4: The first command is precharge-all, encoded as 4'b0010. In that cycle address bit 10 is 1, every other address bit is 0 and `sd_ba` is 0.
- R5: Auto-refresh is encoded as 4'b0001, with `sd_addr` and `sd_ba` zero. The first refresh comes T_RP cycles after the precharge.
- R6: Exactly N_REF auto-refresh commands are issued, with consecutive ones T_RC cycles apart.
- R7: The mode-set command, encoded as 4'b0000, comes T_RC cycles after the last refresh. `sd_addr` carries BURST_LEN in bits 2:0, BURST_TYPE in bit 3 and CAS_LAT in bits 6:4, and is zero above bit 6. `sd_ba` is 0.
- R8: Every command occupies exactly one cycle. All other cycles show NOP with `sd_addr` and `sd_ba` zero.
- R9: `init_done` rises T_RSC cycles after the mode-set cycle and stays high until reset. While it is high, the bus shows NOP.
- R10: A reset asserted at any point, including a command cycle or after the ready flag is up, aborts the sequence. After release the whole sequence restarts from the settling delay with the same timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable, held high |
| sd_dqm | output | 1 | Data mask, held high |
| sd_addr | output | ADDR_W | Address lines (A10 flag, mode word) |
| sd_ba | output | BA_W | Bank address, zero throughout |
| init_done | output | 1 | Sequence complete, sticky until reset |

## Verification
Two things can land in the same cycle: an asynchronous reset and a command on the bus. To provoke this, the bench waits until a refresh is visible and drops `rst_n` in that same cycle. It then checks, before the next clock edge, that the bus has returned to NOP and that the ready flag is low. It also drops reset while the ready flag is high. After each release it records the complete command log a second time and checks every command's cycle, encoding and address against the same expected table as the first run.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    PH_PAUSE,
    PH_PRECHG,
    PH_REFRESH,
    PH_MODESET,
    PH_READY
  } init_phase_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdram_cmd_t;

  localparam sdram_cmd_t CMD_NOP = sdram_cmd_t'(4'b0111);
  localparam sdram_cmd_t CMD_PRE = sdram_cmd_t'(4'b0010);
  localparam sdram_cmd_t CMD_REF = sdram_cmd_t'(4'b0001);
  localparam sdram_cmd_t CMD_MRS = sdram_cmd_t'(4'b0000);

endpackage

// File: rtl/sdram_rst_sync.sv
// Asynchronous assert, synchronous release.
module sdram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/sdram_gap_timer.sv
// Down counter: loads a value, counts to zero, then holds there.
module sdram_gap_timer #(
  parameter int             CNT_W = 8,
  parameter logic [CNT_W-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= INIT;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_cmd_drive.sv
// Decodes the sequencer phase into command pins and address lines.
module sdram_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter int                BA_W      = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  init_phase_e       phase,
  input  logic              issue,
  output sdram_cmd_t        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);

  localparam logic [ADDR_W-1:0] ALL_BANKS = {{(ADDR_W-11){1'b0}}, 1'b1, 10'b0};

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    ba   = '0;
    if (issue) begin
      case (phase)
        PH_PRECHG: begin
          cmd  = CMD_PRE;
          addr = ALL_BANKS;
        end
        PH_REFRESH: cmd = CMD_REF;
        PH_MODESET: begin
          cmd  = CMD_MRS;
          addr = MODE_WORD;
        end
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int       T_PAUSE    = 20000,
  parameter int       T_RP       = 3,
  parameter int       T_RC       = 7,
  parameter int       T_RSC      = 2,
  parameter int       N_REF      = 8,
  parameter int       ADDR_W     = 12,
  parameter int       BA_W       = 2,
  parameter logic [2:0] BURST_LEN  = 3'b011,
  parameter logic       BURST_TYPE = 1'b0,
  parameter logic [2:0] CAS_LAT    = 3'b011
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic              sd_dqm,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              init_done
);

  localparam int T_MAX_A = (T_PAUSE > T_RP) ? T_PAUSE : T_RP;
  localparam int T_MAX_B = (T_RC > T_RSC) ? T_RC : T_RSC;
  localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
  localparam int CNT_W   = $clog2(T_MAX + 1);
  localparam int REF_W   = $clog2(N_REF) + 1;
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(N_REF - 1);
  localparam logic [ADDR_W-1:0] MODE_WORD =
    {{(ADDR_W-7){1'b0}}, CAS_LAT, BURST_TYPE, BURST_LEN};

  logic             srst_n;
  init_phase_e      phase_q, phase_d;
  logic             issue_q, issue_d;
  logic [REF_W-1:0] ref_q, ref_d;
  logic             expired;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  sdram_cmd_t       cmd;

  sdram_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sdram_gap_timer #(
    .CNT_W (CNT_W),
    .INIT  (CNT_W'(T_PAUSE - 1))
  ) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  // Next-state logic: a phase is left only when its gap has run out.
  always_comb begin
    phase_d  = phase_q;
    issue_d  = 1'b0;
    ref_d    = ref_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (expired) begin
      case (phase_q)
        PH_PAUSE: begin
          phase_d  = PH_PRECHG;
          issue_d  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_RP - 1);
        end
        PH_PRECHG: begin
          phase_d  = PH_REFRESH;
          issue_d  = 1'b1;
          ref_d    = '0;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_RC - 1);
        end
        PH_REFRESH: begin
          issue_d  = 1'b1;
          tmr_load = 1'b1;
          if (ref_q == REF_LAST) begin
            phase_d = PH_MODESET;
            tmr_val = CNT_W'(T_RSC - 1);
          end else begin
            ref_d   = ref_q + 1'b1;
            tmr_val = CNT_W'(T_RC - 1);
          end
        end
        PH_MODESET: phase_d = PH_READY;
        default:    phase_d = PH_READY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase_q <= PH_PAUSE;
      issue_q <= 1'b0;
      ref_q   <= '0;
    end else begin
      issue_q <= issue_d;
      if (expired) begin
        phase_q <= phase_d;
        ref_q   <= ref_d;
      end
    end
  end

  sdram_cmd_drive #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .MODE_WORD (MODE_WORD)
  ) u_drive (
    .phase (phase_q),
    .issue (issue_q),
    .cmd   (cmd),
    .addr  (sd_addr),
    .ba    (sd_ba)
  );

  assign sd_cs_n   = cmd.cs_n;
  assign sd_ras_n  = cmd.ras_n;
  assign sd_cas_n  = cmd.cas_n;
  assign sd_we_n   = cmd.we_n;
  assign sd_cke    = 1'b1;
  assign sd_dqm    = 1'b1;
  assign init_done = (phase_q == PH_READY);

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
  parameter int N_REF  = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              init_done
);

  logic [3:0] bus;
  logic       is_nop, is_pre, is_ref, is_mrs;
  int         ref_seen;
  logic       pre_seen;

  assign bus    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_nop = (bus == 4'b0111);
  assign is_pre = (bus == 4'b0010);
  assign is_ref = (bus == 4'b0001);
  assign is_mrs = (bus == 4'b0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_seen <= 0;
      pre_seen <= 1'b0;
    end else begin
      if (is_ref) ref_seen <= ref_seen + 1;
      if (is_pre) pre_seen <= 1'b1;
    end
  end

  // R8
  one_cycle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |=> is_nop);

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R9
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> is_nop);

  // R6
  ref_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (ref_seen == N_REF));

  // R4
  prechg_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> sd_addr[10]);

  // R5
  ref_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> pre_seen);

endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
  .N_REF  (N_REF),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_addr   (sd_addr),
  .init_done (init_done)
);

// File: tb/sdram_pwrup_seq_tb.sv
`timescale 1ns/1ps
module sdram_pwrup_seq_tb;

  localparam int TP = 50;
  localparam int TR = 3;
  localparam int TC = 7;
  localparam int TS = 2;
  localparam int NR = 8;
  localparam int AW = 12;
  localparam int BW = 2;
  localparam int NEV = NR + 2;
  localparam int E0 = TP + 2;
  localparam int MRS_EDGE  = E0 + TR + NR * TC;
  localparam int DONE_EDGE = MRS_EDGE + TS;

  // Expected command log: edge after release, {cs,ras,cas,we}, address.
  localparam int EXP_EDGE [NEV] = '{E0, E0+TR, E0+TR+TC, E0+TR+2*TC,
    E0+TR+3*TC, E0+TR+4*TC, E0+TR+5*TC, E0+TR+6*TC, E0+TR+7*TC, MRS_EDGE};
  localparam logic [3:0] EXP_CMD [NEV] = '{4'b0010, 4'b0001, 4'b0001,
    4'b0001, 4'b0001, 4'b0001, 4'b0001, 4'b0001, 4'b0001, 4'b0000};
  localparam logic [AW-1:0] EXP_ADDR [NEV] = '{12'h400, 12'h000, 12'h000,
    12'h000, 12'h000, 12'h000, 12'h000, 12'h000, 12'h000, 12'h02B};

  logic          clk;
  logic          rst_n;
  logic          sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_dqm;
  logic [AW-1:0] sd_addr;
  logic [BW-1:0] sd_ba;
  logic          init_done;

  int checks;
  int errors;
  int edge_n;
  int nev;
  int done_edge;
  int cke_bad;
  int       ev_edge [16];
  logic [3:0] ev_cmd [16];
  logic [AW-1:0] ev_addr [16];
  logic [BW-1:0] ev_ba [16];

  sdram_pwrup_seq #(
    .T_PAUSE (TP), .T_RP (TR), .T_RC (TC), .T_RSC (TS), .N_REF (NR),
    .ADDR_W (AW), .BA_W (BW),
    .BURST_LEN (3'b011), .BURST_TYPE (1'b1), .CAS_LAT (3'b010)
  ) u_dut (
    .clk (clk), .rst_n (rst_n),
    .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n),
    .sd_we_n (sd_we_n), .sd_cke (sd_cke), .sd_dqm (sd_dqm),
    .sd_addr (sd_addr), .sd_ba (sd_ba), .init_done (init_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_n <= 0;
    else        edge_n <= edge_n + 1;
  end

  // Monitor: logs every non-NOP command with the edge it followed.
  always @(negedge clk) begin
    if (!(sd_cke && sd_dqm)) cke_bad = cke_bad + 1;
    if (!rst_n) begin
      nev = 0;
      done_edge = -1;
    end else begin
      if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != 4'b0111 && nev < 16) begin
        ev_edge[nev] = edge_n;
        ev_cmd[nev]  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        ev_addr[nev] = sd_addr;
        ev_ba[nev]   = sd_ba;
        nev = nev + 1;
      end
      if (init_done && done_edge < 0) done_edge = edge_n;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, {tag, " bus NOP"},
        int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
    chk(sd_addr == '0 && sd_ba == '0, {tag, " addr/ba zero"}, int'(sd_addr), 0);
    chk(init_done == 1'b0, {tag, " done low"}, int'(init_done), 0);
    chk(sd_cke && sd_dqm, {tag, " cke/dqm high R3"}, int'({sd_cke, sd_dqm}), 3);
  endtask

  function automatic string tag_of(input int i);
    if (i == 0) return "R2 R4 precharge";
    if (i == NEV - 1) return "R7 mode set";
    return "R5 R6 refresh";
  endfunction

  task automatic run_and_check(input string run);
    while (edge_n < DONE_EDGE + 5) @(negedge clk);
    chk(nev == NEV, {run, " R6 R8 command count"}, nev, NEV);
    for (int i = 0; i < NEV; i++) begin
      chk(ev_edge[i] == EXP_EDGE[i], {run, " ", tag_of(i), " edge"}, ev_edge[i], EXP_EDGE[i]);
      chk(ev_cmd[i] == EXP_CMD[i], {run, " ", tag_of(i), " encoding"},
          int'(ev_cmd[i]), int'(EXP_CMD[i]));
      chk(ev_addr[i] == EXP_ADDR[i], {run, " ", tag_of(i), " address"},
          int'(ev_addr[i]), int'(EXP_ADDR[i]));
      chk(ev_ba[i] == '0, {run, " ", tag_of(i), " bank"}, int'(ev_ba[i]), 0);
    end
    chk(done_edge == DONE_EDGE, {run, " R9 done edge"}, done_edge, DONE_EDGE);
    repeat (20) @(negedge clk);
    chk(init_done == 1'b1, {run, " R9 done sticky"}, int'(init_done), 1);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, {run, " R9 NOP after done"},
        int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
    chk(nev == NEV, {run, " R8 no command after done"}, nev, NEV);
  endtask

  initial begin
    #(200000 * 10);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    cke_bad = 0;
    nev = 0;
    done_edge = -1;
    rst_n = 1'b0;
    #3;
    check_idle("R1 before first edge");
    repeat (3) @(negedge clk);
    check_idle("R1 clocked reset");

    // First full sequence.
    rst_n = 1'b1;
    run_and_check("run1");

    // R10: reset while done is high.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle("R10 reset from done");
    repeat (2) @(negedge clk);

    // R10: reset in the same cycle as a refresh command.
    rst_n = 1'b1;
    while (edge_n < EXP_EDGE[3]) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0001, "R5 refresh on bus before abort",
        int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 1);
    rst_n = 1'b0;
    #1;
    check_idle("R1 R10 reset during refresh");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_and_check("R10 restart");

    chk(cke_bad == 0, "R3 cke/dqm high every cycle", cke_bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule